// File: doc/BRIEF.md
# DMA Channel Hop Sequencer

This block is a single DMA channel that moves data in hops. A hop reads one burst of 1, 2 or 4 elements from a source address into a small internal buffer. It then writes the same number of elements to a destination address. The channel stops after a programmed number of hops.

Before each hop, the channel waits for a trigger. The trigger source is set by a 2-bit type field:

- a software start that needs no request line,
- one selected line of a hardware request vector,
- the level of an external request line,
- a rising edge of the external request line.

A hold bit sets how the bus is used. When the bit is 0, the channel drops its bus request after every hop, so another master can take the bus. When the bit is 1, one trigger runs every hop back to back while the bus is kept.

The bus port is a simple single-cycle master port. The channel raises `busReq` and waits for `busGnt`. Each cycle with `busValid` high is one complete read or write, and read data is returned in that same cycle. Software pulses `enSet` to start the channel. The configuration is captured on that pulse. At the end of a transfer the channel sets `done` and clears `chanEnable`.

Top module: `hop_dma_channel`

## Requirements
- R1: After reset, `busReq`, `busValid`, `done` and `chanEnable` are all 0.
- R2: A hop is N reads followed by N writes, and all reads finish before the first write. N is set by `cfgBurst`: 00 gives 1, 01 gives 2, 10 and 11 give 4.
- R3: The source and destination addresses start at `cfgSrc` and `cfgDst`. Each one advances by the element size after every read or write, and keeps advancing across hops. The element size is set by `cfgWidth`: 00 is 1 byte, 01 is 2 bytes, 10 and 11 are 4 bytes.
- R4: The k-th write of a hop carries the data of the k-th read of that hop. Bits above the element width are zeroed (width 00 keeps bits 7:0, width 01 keeps bits 15:0).
- R5: With `cfgHold`=0, `busReq` goes low for at least one cycle after every hop. With `cfgHold`=1, `busReq` stays high from the first hop until the last write.
- R6: With `cfgHold`=1, a single trigger runs all programmed hops.
- R7: Type 10 (software) starts on `enSet` and needs no request line.
- R8: Type 01 (hardware) triggers when `hwReq[cfgSel]` is high. All other `hwReq` lines are ignored.
- R9: Type 11 (level) starts a hop only while `extReq` is high.
- R10: Type 00 (edge) starts a hop only after a rising edge of `extReq`. A level that is held high does not retrigger. A rising edge that arrives during a hop is stored and starts the next hop.
- R11: After `cfgHops` hops, `done` goes to 1 and `chanEnable` goes to 0. A hop count of 0 completes at once with no bus cycle.
- R12: An `enSet` pulse while idle clears `done`, raises `chanEnable` on the next cycle and captures a new configuration.
- R13: A bus cycle (`busValid`=1) occurs only while both `busReq` and `busGnt` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enSet | input | 1 | Start pulse; captures the configuration when the channel is idle |
| cfgType | input | 2 | Trigger type: 00 edge, 01 hardware, 10 software, 11 level |
| cfgHold | input | 1 | 1 keeps the bus for the whole transfer |
| cfgBurst | input | 2 | Burst length code |
| cfgWidth | input | 2 | Element width code |
| cfgSel | input | SEL_W (3) | Selects which hardware request line is used |
| cfgHops | input | HOP_W (8) | Number of hops |
| cfgSrc | input | AW (16) | Source start address |
| cfgDst | input | AW (16) | Destination start address |
| hwReq | input | NSRC (8) | Hardware request lines |
| extReq | input | 1 | External request line |
| busReq | output | 1 | Bus request |
| busGnt | input | 1 | Bus grant |
| busValid | output | 1 | A bus cycle completes in this cycle |
| busWe | output | 1 | 1 for a write cycle, 0 for a read cycle |
| busAddr | output | AW (16) | Bus address |
| busWData | output | DW (32) | Write data |
| busRData | input | DW (32) | Read data, valid in the same cycle |
| chanEnable | output | 1 | Channel is active |
| done | output | 1 | Transfer has completed |

## Verification
The assertions assume three things about the inputs:
- The grant is dropped only while no request is raised, or with a delay.
- Read data is valid in the same cycle as `busValid`.
- `enSet` is pulsed only while the channel is idle.

The stimulus meets these assumptions. The grant is a register that follows `busReq` one cycle later. Read data is a pure function of `busAddr`. Each start pulse is issued only after `done` has been seen.

// File: rtl/hop_dma_pkg.sv
package hop_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ARB,
    ST_READ,
    ST_WRITE
  } chanState_t;

  typedef struct packed {
    logic loadCfg;
    logic rdBeat;
    logic wrBeat;
    logic hopDone;
    logic inWrite;
  } dpStrobe_t;

  localparam logic [1:0] TYPE_EDGE  = 2'b00;
  localparam logic [1:0] TYPE_HW    = 2'b01;
  localparam logic [1:0] TYPE_SW    = 2'b10;
  localparam logic [1:0] TYPE_LEVEL = 2'b11;
endpackage

// File: rtl/hop_dma_datapath.sv
module hop_dma_datapath
  import hop_dma_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int MAX_BURST = 4,
  parameter int HOP_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [1:0]       cfgBurst,
  input  logic [1:0]       cfgWidth,
  input  logic [HOP_W-1:0] cfgHops,
  input  logic [AW-1:0]    cfgSrc,
  input  logic [AW-1:0]    cfgDst,
  input  logic [DW-1:0]    busRData,
  output logic [AW-1:0]    busAddr,
  output logic [DW-1:0]    busWData,
  output logic             atLast,
  output logic             lastHop
);
  localparam int BEAT_W = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1;
  localparam int LOG_MAX = $clog2(MAX_BURST);
  localparam logic [1:0] MAX_CODE = 2'(LOG_MAX);

  logic [1:0]        burstCode, widthCode;
  logic [AW-1:0]     srcCur, dstCur, step;
  logic [HOP_W-1:0]  hopsLeft;
  logic [BEAT_W-1:0] beatCnt, beatLast;
  logic [DW-1:0]     dataMask;
  logic [DW-1:0]     bufMem [MAX_BURST];
  logic [1:0]        effCode;

  always_comb begin
    effCode  = (burstCode > MAX_CODE) ? MAX_CODE : burstCode;
    beatLast = BEAT_W'((32'd1 << effCode) - 32'd1);
    if (widthCode[1])      step = AW'(4);
    else if (widthCode[0]) step = AW'(2);
    else                   step = AW'(1);
    if (widthCode[1])      dataMask = '1;
    else if (widthCode[0]) dataMask = DW'(16'hFFFF);
    else                   dataMask = DW'(8'hFF);
  end

  assign atLast   = (beatCnt == beatLast);
  assign lastHop  = (hopsLeft == HOP_W'(1));
  assign busAddr  = strobe.inWrite ? dstCur : srcCur;
  assign busWData = bufMem[beatCnt];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstCode <= '0;
      widthCode <= '0;
      srcCur    <= '0;
      dstCur    <= '0;
      hopsLeft  <= '0;
      beatCnt   <= '0;
    end else if (strobe.loadCfg) begin
      burstCode <= cfgBurst;
      widthCode <= cfgWidth;
      srcCur    <= cfgSrc;
      dstCur    <= cfgDst;
      hopsLeft  <= cfgHops;
      beatCnt   <= '0;
    end else begin
      if (strobe.rdBeat) srcCur <= srcCur + step;
      if (strobe.wrBeat) dstCur <= dstCur + step;
      if (strobe.rdBeat || strobe.wrBeat)
        beatCnt <= atLast ? '0 : beatCnt + BEAT_W'(1);
      if (strobe.hopDone) hopsLeft <= hopsLeft - HOP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MAX_BURST; i++) bufMem[i] <= '0;
    end else if (strobe.rdBeat) begin
      for (int i = 0; i < MAX_BURST; i++)
        if (beatCnt == BEAT_W'(i)) bufMem[i] <= busRData & dataMask;
    end
  end

  AST_BEAT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    beatCnt <= beatLast); // R2
  AST_SRC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdBeat && !strobe.loadCfg) |=> srcCur == $past(srcCur + step)); // R3
  AST_DST_STILL_IN_READ: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdBeat && !strobe.loadCfg) |=> $stable(dstCur)); // R2
  AST_HOP_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.hopDone && !strobe.loadCfg) |=> hopsLeft == $past(hopsLeft) - HOP_W'(1)); // R11
endmodule

// File: rtl/hop_dma_control.sv
module hop_dma_control
  import hop_dma_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int HOP_W = 8,
  localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enSet,
  input  logic [1:0]       cfgType,
  input  logic             cfgHold,
  input  logic [SEL_W-1:0] cfgSel,
  input  logic [HOP_W-1:0] cfgHops,
  input  logic [NSRC-1:0]  hwReq,
  input  logic             extReq,
  input  logic             busGnt,
  input  logic             atLast,
  input  logic             lastHop,
  output dpStrobe_t        strobe,
  output logic             busReq,
  output logic             busWe,
  output logic             busValid,
  output logic             chanEnable,
  output logic             done
);
  chanState_t       state, stateNext;
  logic [1:0]       typLat;
  logic             holdLat;
  logic [SEL_W-1:0] selLat;
  logic             extPrev, pend, edgeRise, trig, start;
  logic             rdGo, wrGo, hopEnd, idleStart;

  assign edgeRise  = extReq & ~extPrev;
  assign idleStart = (state == ST_IDLE) && enSet;
  assign start     = (state == ST_WAIT) && trig;
  assign rdGo      = (state == ST_READ) && busGnt;
  assign wrGo      = (state == ST_WRITE) && busGnt;
  assign hopEnd    = wrGo && atLast;

  always_comb begin
    case (typLat)
      TYPE_EDGE:  trig = pend | edgeRise;
      TYPE_HW:    trig = hwReq[selLat];
      TYPE_SW:    trig = 1'b1;
      default:    trig = extReq;
    endcase
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (enSet && cfgHops != '0) stateNext = ST_WAIT;
      ST_WAIT:  if (trig) stateNext = ST_ARB;
      ST_ARB:   if (busGnt) stateNext = ST_READ;
      ST_READ:  if (rdGo && atLast) stateNext = ST_WRITE;
      ST_WRITE: if (hopEnd) begin
                  if (lastHop)      stateNext = ST_IDLE;
                  else if (holdLat) stateNext = ST_READ;
                  else              stateNext = ST_WAIT;
                end
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.loadCfg = idleStart;
    strobe.rdBeat  = rdGo;
    strobe.wrBeat  = wrGo;
    strobe.hopDone = hopEnd;
    strobe.inWrite = (state == ST_WRITE);
  end

  assign busReq     = (state == ST_ARB) || (state == ST_READ) || (state == ST_WRITE);
  assign busWe      = (state == ST_WRITE);
  assign busValid   = rdGo || wrGo;
  assign chanEnable = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      typLat  <= '0;
      holdLat <= 1'b0;
      selLat  <= '0;
      done    <= 1'b0;
      extPrev <= 1'b0;
      pend    <= 1'b0;
    end else begin
      state   <= stateNext;
      extPrev <= extReq;
      if (idleStart) begin
        typLat  <= cfgType;
        holdLat <= cfgHold;
        selLat  <= cfgSel;
        done    <= (cfgHops == '0);
      end else if (hopEnd && lastHop) begin
        done <= 1'b1;
      end
      if (state == ST_IDLE || start) pend <= 1'b0;
      else if (typLat == TYPE_EDGE && edgeRise) pend <= 1'b1;
    end
  end

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !busReq && !busValid); // R1
  AST_VALID_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> busReq && busGnt); // R13
  AST_RELEASE_AFTER_HOP: assert property (@(posedge clk) disable iff (!rstN)
    (hopEnd && !holdLat) |=> !busReq); // R5
  AST_HOLD_KEEPS_BUS: assert property (@(posedge clk) disable iff (!rstN)
    (hopEnd && holdLat && !lastHop) |=> busReq); // R5
  AST_DONE_NOT_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !chanEnable); // R11
  AST_EDGE_STORED: assert property (@(posedge clk) disable iff (!rstN)
    (typLat == TYPE_EDGE && edgeRise && busReq) |=> pend); // R10
  AST_WRITE_AFTER_READS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busWe) |-> $past(state) == ST_READ); // R2
endmodule

// File: rtl/hop_dma_channel.sv
module hop_dma_channel
  import hop_dma_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int MAX_BURST = 4,
  parameter int HOP_W     = 8,
  parameter int NSRC      = 8,
  localparam int SEL_W    = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enSet,
  input  logic [1:0]       cfgType,
  input  logic             cfgHold,
  input  logic [1:0]       cfgBurst,
  input  logic [1:0]       cfgWidth,
  input  logic [SEL_W-1:0] cfgSel,
  input  logic [HOP_W-1:0] cfgHops,
  input  logic [AW-1:0]    cfgSrc,
  input  logic [AW-1:0]    cfgDst,
  input  logic [NSRC-1:0]  hwReq,
  input  logic             extReq,
  output logic             busReq,
  input  logic             busGnt,
  output logic             busValid,
  output logic             busWe,
  output logic [AW-1:0]    busAddr,
  output logic [DW-1:0]    busWData,
  input  logic [DW-1:0]    busRData,
  output logic             chanEnable,
  output logic             done
);
  dpStrobe_t strobe;
  logic      atLast, lastHop;

  hop_dma_control #(.NSRC(NSRC), .HOP_W(HOP_W)) i_control (
    .clk(clk), .rstN(rstN), .enSet(enSet), .cfgType(cfgType), .cfgHold(cfgHold),
    .cfgSel(cfgSel), .cfgHops(cfgHops), .hwReq(hwReq), .extReq(extReq),
    .busGnt(busGnt), .atLast(atLast), .lastHop(lastHop), .strobe(strobe),
    .busReq(busReq), .busWe(busWe), .busValid(busValid),
    .chanEnable(chanEnable), .done(done)
  );

  hop_dma_datapath #(.AW(AW), .DW(DW), .MAX_BURST(MAX_BURST), .HOP_W(HOP_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgBurst(cfgBurst),
    .cfgWidth(cfgWidth), .cfgHops(cfgHops), .cfgSrc(cfgSrc), .cfgDst(cfgDst),
    .busRData(busRData), .busAddr(busAddr), .busWData(busWData),
    .atLast(atLast), .lastHop(lastHop)
  );
endmodule

// File: tb/test_hop_dma_channel.sv
`timescale 1ns/1ps
module test_hop_dma_channel;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enSet = 1'b0;
  logic [1:0]  cfgType = 2'b10;
  logic        cfgHold = 1'b0;
  logic [1:0]  cfgBurst = '0;
  logic [1:0]  cfgWidth = '0;
  logic [2:0]  cfgSel = '0;
  logic [7:0]  cfgHops = '0;
  logic [15:0] cfgSrc = '0;
  logic [15:0] cfgDst = '0;
  logic [7:0]  hwReq = '0;
  logic        extReq = 1'b0;
  logic        busReq, busValid, busWe, chanEnable, done;
  logic        busGnt = 1'b0;
  logic [15:0] busAddr;
  logic [31:0] busWData, busRData;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic        logWe   [64];
  logic [15:0] logAddr [64];
  logic [31:0] logData [64];
  int          logN = 0;
  int          relCount = 0;
  logic        prevReq = 1'b0;

  always #2 clk = ~clk;

  hop_dma_channel i_hop_dma_channel (
    .clk(clk), .rstN(rstN), .enSet(enSet), .cfgType(cfgType), .cfgHold(cfgHold),
    .cfgBurst(cfgBurst), .cfgWidth(cfgWidth), .cfgSel(cfgSel), .cfgHops(cfgHops),
    .cfgSrc(cfgSrc), .cfgDst(cfgDst), .hwReq(hwReq), .extReq(extReq),
    .busReq(busReq), .busGnt(busGnt), .busValid(busValid), .busWe(busWe),
    .busAddr(busAddr), .busWData(busWData), .busRData(busRData),
    .chanEnable(chanEnable), .done(done)
  );

  function automatic logic [31:0] memWord(input logic [15:0] a);
    return {~a, a};
  endfunction

  assign busRData = memWord(busAddr);

  always @(posedge clk) busGnt <= busReq;

  always @(negedge clk) begin
    if (busValid && logN < 64) begin
      logWe[logN]   = busWe;
      logAddr[logN] = busAddr;
      logData[logN] = busWData;
      logN = logN + 1;
    end
    if (prevReq && !busReq) relCount = relCount + 1;
    prevReq = busReq;
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic startRun(input logic [1:0] typ, input logic hold, input logic [1:0] burst,
                          input logic [1:0] width, input logic [2:0] sel, input logic [7:0] hops,
                          input logic [15:0] src, input logic [15:0] dst);
    @(negedge clk);
    cfgType = typ; cfgHold = hold; cfgBurst = burst; cfgWidth = width;
    cfgSel = sel; cfgHops = hops; cfgSrc = src; cfgDst = dst;
    logN = 0; relCount = 0;
    enSet = 1'b1;
    @(negedge clk);
    enSet = 1'b0;
  endtask

  task automatic waitDone(input int maxc);
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (done) break;
    end
    chk(done == 1'b1, "R11 done flag set", 32'(done), 32'd1);
    chk(chanEnable == 1'b0, "R11 enable cleared", 32'(chanEnable), 32'd0);
    @(negedge clk);
  endtask

  task automatic verifyLog(input int hops, input int burst, input int width,
                           input logic [15:0] src, input logic [15:0] dst);
    int bs, elem;
    logic [31:0] mask;
    bs   = (burst == 0) ? 1 : (burst == 1) ? 2 : 4;
    elem = (width == 0) ? 1 : (width == 1) ? 2 : 4;
    mask = (width == 0) ? 32'hFF : (width == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    chk(logN == 2 * hops * bs, "R2 bus cycle count", 32'(logN), 32'(2 * hops * bs));
    if (logN == 2 * hops * bs) begin
      for (int h = 0; h < hops; h++) begin
        for (int b = 0; b < bs; b++) begin
          int ri, wi;
          logic [15:0] ra, wa;
          ri = h * 2 * bs + b;
          wi = ri + bs;
          ra = src + 16'((h * bs + b) * elem);
          wa = dst + 16'((h * bs + b) * elem);
          chk(logWe[ri] == 1'b0, "R2 read phase first", 32'(logWe[ri]), 32'd0);
          chk(logAddr[ri] == ra, "R3 source address", 32'(logAddr[ri]), 32'(ra));
          chk(logWe[wi] == 1'b1, "R2 write phase second", 32'(logWe[wi]), 32'd1);
          chk(logAddr[wi] == wa, "R3 destination address", 32'(logAddr[wi]), 32'(wa));
          chk(logData[wi] == (memWord(ra) & mask), "R4 write data", logData[wi], memWord(ra) & mask);
        end
      end
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(busReq == 1'b0, "R1 reset busReq", 32'(busReq), 0);
    chk(busValid == 1'b0, "R1 reset busValid", 32'(busValid), 0);
    chk(done == 1'b0, "R1 reset done", 32'(done), 0);
    chk(chanEnable == 1'b0, "R1 reset enable", 32'(chanEnable), 0);

    // R7 software sweep over burst, width and hold (R2 R3 R4 R5 R12)
    for (int bu = 0; bu < 4; bu++) begin
      for (int wd = 0; wd < 3; wd++) begin
        for (int ho = 0; ho < 2; ho++) begin
          logic [15:0] src, dst;
          src = 16'h0100 + 16'(bu * 64 + wd * 16);
          dst = 16'h8000 + 16'(ho * 256 + wd * 32);
          startRun(2'b10, 1'(ho), 2'(bu), 2'(wd), 3'd0, 8'd3, src, dst);
          chk(done == 1'b0, "R12 done cleared on start", 32'(done), 0);
          chk(chanEnable == 1'b1, "R12 enable raised", 32'(chanEnable), 1);
          waitDone(400);
          verifyLog(3, bu, wd, src, dst);
          chk(relCount == (ho ? 1 : 3), "R5 bus releases", 32'(relCount), ho ? 1 : 3);
        end
      end
    end

    // R10 edge type: held level ignored, edge during hop stored
    extReq = 1'b1;
    repeat (3) @(negedge clk);
    startRun(2'b00, 1'b0, 2'd1, 2'd2, 3'd0, 8'd3, 16'h2000, 16'h3000);
    repeat (20) @(negedge clk);
    chk(logN == 0, "R10 held level no start", 32'(logN), 0);
    extReq = 1'b0;
    @(negedge clk); extReq = 1'b1;
    @(negedge clk); extReq = 1'b0;
    repeat (3) @(negedge clk);
    extReq = 1'b1;
    @(negedge clk); extReq = 1'b0;
    repeat (40) @(negedge clk);
    chk(logN == 8, "R10 stored edge runs second hop only", 32'(logN), 8);
    chk(done == 1'b0, "R10 waits for third edge", 32'(done), 0);
    extReq = 1'b1;
    @(negedge clk); extReq = 1'b0;
    waitDone(200);
    verifyLog(3, 1, 2, 16'h2000, 16'h3000);

    // R9 level type
    startRun(2'b11, 1'b0, 2'd0, 2'd0, 3'd0, 8'd3, 16'h4001, 16'h5003);
    repeat (20) @(negedge clk);
    chk(logN == 0, "R9 low level no start", 32'(logN), 0);
    extReq = 1'b1;
    waitDone(200);
    extReq = 1'b0;
    verifyLog(3, 0, 0, 16'h4001, 16'h5003);
    chk(relCount == 3, "R9 R5 releases per hop", 32'(relCount), 3);

    // R8 hardware type with hold (R6)
    startRun(2'b01, 1'b1, 2'd2, 2'd1, 3'd3, 8'd2, 16'h6000, 16'h7000);
    repeat (20) @(negedge clk);
    chk(logN == 0, "R8 no request no start", 32'(logN), 0);
    hwReq = 8'h20;
    repeat (20) @(negedge clk);
    chk(logN == 0, "R8 unselected line ignored", 32'(logN), 0);
    hwReq = 8'h08;
    @(negedge clk);
    hwReq = 8'h00;
    waitDone(200);
    verifyLog(2, 2, 1, 16'h6000, 16'h7000);
    chk(relCount == 1, "R6 one trigger all hops, bus held", 32'(relCount), 1);

    // R11 zero hops
    startRun(2'b10, 1'b0, 2'd0, 2'd0, 3'd0, 8'd0, 16'h0, 16'h0);
    chk(done == 1'b1, "R11 zero hops done", 32'(done), 1);
    chk(chanEnable == 1'b0, "R11 zero hops idle", 32'(chanEnable), 0);
    repeat (5) @(negedge clk);
    chk(logN == 0, "R11 zero hops no bus cycle", 32'(logN), 0);
    chk(busReq == 1'b0, "R13 no request when idle", 32'(busReq), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule